// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Guard

The guard sits on the active-low chip-enable path between a host and a static memory. While the supply is healthy and settled, the memory enable is the host enable, passed through combinationally. An external comparator raises a power-fail flag when the supply drops out of tolerance. The guard then write-protects the memory by holding its enable inactive (high).

Protection is not applied blindly. If the host is in the middle of an access when the fault is seen, that access may finish. It ends when the host releases its enable or when a short grace window runs out, whichever happens first. From then on the memory stays blocked. After the supply is good again, the block waits out a recovery interval before it hands the enable back to the host.

All timing is counted in ticks of a free-running tick input, so the grace window and the recovery interval are parameters. A status output reports when protection is in force.

Top module: `pfce_guard`

## Requirements
- R1: Synchronous reset puts the guard in the recovering state. After reset, `protect_on` is 1 and `mem_ce_n` is 1, whatever the host enable does, until the recovery interval has elapsed.
- R2: With protection off and no fault pending, `mem_ce_n` equals `host_ce_n` in the same cycle, with no register on the path.
- R3: `pwr_fail` passes through a two-stage synchronizer. A change applied before rising edge k takes effect on the guard's state at edge k+2, so outputs react after the third edge.
- R4: If `host_ce_n` is 1 when the synchronized fault is seen, the guard locks at that edge: `mem_ce_n` and `protect_on` go to 1 and stay there while the fault lasts, even if the host drives its enable low.
- R5: If `host_ce_n` is 0 when the fault is seen, `mem_ce_n` keeps following the host. Once the host drives its enable to 1, the guard locks and `mem_ce_n` stays 1 while the fault lasts, even if the host drives low again.
- R6: If the host still holds its enable low after GRACE_TICKS ticks counted from fault detection, the guard locks at that tick and forces `mem_ce_n` to 1.
- R7: After the synchronized fault clears, the guard stays locked for RECOV_TICKS ticks. It then returns to following the host.
- R8: A fault during the recovery interval returns the guard to the locked state. Recovery restarts from zero once the fault clears.
- R9: If the fault clears while an access is still passing through under grace, the guard moves straight into recovery, and `mem_ce_n` is forced to 1 at once.
- R10: `protect_on` is 1 exactly when the guard is locked or recovering. It is 0 while passing through under grace. Whenever it is 1, `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_ce_n | input | 1 | Host chip-enable, active low |
| pwr_fail | input | 1 | Asynchronous supply-fault flag from the comparator, active high |
| us_tick | input | 1 | One-cycle timing tick |
| mem_ce_n | output | 1 | Gated chip-enable to the memory, active low |
| protect_on | output | 1 | High while write protection is in force |

## Verification
The assertions assume that `pwr_fail` is only observed through the synchronizer, and that `host_ce_n` is stable around the clock edge at which the guard samples it. The bench therefore changes every input away from the rising edge. The assertions also assume that `us_tick` is a single-cycle pulse. The bench drives it as a one-in-three-cycles pulse and changes the fault flag only on falling edges. Fault episodes are spaced so that entry during an access, entry while idle, a re-fault during recovery and a clear during grace each occur at least once.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    // Guard operating states
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,   // supply good, enable passes through
        GS_PASS  = 2'd1,   // fault seen, access still allowed under grace
        GS_LOCK  = 2'd2,   // fault, memory blocked
        GS_RECOV = 2'd3    // supply back, blocked while settling
    } guard_state_e;

    // Bits needed to count 0 .. n-1
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic blocks_memory(input guard_state_e s);
        return (s == GS_LOCK) || (s == GS_RECOV);
    endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfce_tick_cnt.sv
module pfce_tick_cnt #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = pfce_pkg::cnt_bits(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (done)   cnt <= '0;
        else if (en)     cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pfce_fsm.sv
module pfce_fsm
    import pfce_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         pf_sync,
    input  logic         host_ce_n,
    input  logic         grace_done,
    input  logic         recov_done,
    output guard_state_e state
);
    guard_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            GS_RUN:   if (pf_sync) nxt = host_ce_n ? GS_LOCK : GS_PASS;
            GS_PASS:  if (!pf_sync)                    nxt = GS_RECOV;
                      else if (host_ce_n || grace_done) nxt = GS_LOCK;
            GS_LOCK:  if (!pf_sync) nxt = GS_RECOV;
            GS_RECOV: if (pf_sync)         nxt = GS_LOCK;
                      else if (recov_done) nxt = GS_RUN;
            default:  nxt = GS_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GS_RECOV;
        else     state <= nxt;
    end
endmodule

// File: rtl/pfce_guard.sv
module pfce_guard
    import pfce_pkg::*;
#(
    parameter int GRACE_TICKS = 3,       // 0.5 us ticks: 1.5 us
    parameter int RECOV_TICKS = 100000,  // 0.5 us ticks: 50 ms
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_ce_n,
    input  logic pwr_fail,
    input  logic us_tick,
    output logic mem_ce_n,
    output logic protect_on
);
    logic         pf_sync;
    guard_state_e state;
    logic         grace_done;
    logic         recov_done;

    pfce_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (pwr_fail), .q (pf_sync)
    );

    pfce_tick_cnt #(.LIMIT(GRACE_TICKS)) u_grace (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != GS_PASS),
        .en   (us_tick && (state == GS_PASS)),
        .done (grace_done)
    );

    pfce_tick_cnt #(.LIMIT(RECOV_TICKS)) u_recov (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != GS_RECOV),
        .en   (us_tick && (state == GS_RECOV)),
        .done (recov_done)
    );

    pfce_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pf_sync    (pf_sync),
        .host_ce_n  (host_ce_n),
        .grace_done (grace_done),
        .recov_done (recov_done),
        .state      (state)
    );

    assign protect_on = blocks_memory(state);
    assign mem_ce_n   = protect_on ? 1'b1 : host_ce_n;
endmodule

// File: rtl/pfce_guard_chk.sv
module pfce_guard_chk (
    input logic clk,
    input logic rst,
    input logic host_ce_n,
    input logic pf_sync,
    input logic mem_ce_n,
    input logic protect_on
);
    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        protect_on |-> mem_ce_n); // R10

    AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !protect_on |-> (mem_ce_n == host_ce_n)); // R2

    AST_LOCK_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pf_sync && !protect_on && host_ce_n) |=> protect_on); // R5

    AST_HOLD_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
        (protect_on && pf_sync) |=> protect_on); // R8

    AST_EXIT_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
        $fell(protect_on) |-> !$past(pf_sync)); // R7
endmodule

bind pfce_guard pfce_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ce_n  (host_ce_n),
    .pf_sync    (pf_sync),
    .mem_ce_n   (mem_ce_n),
    .protect_on (protect_on)
);

// File: tb/test_pfce_guard.sv
`timescale 1ns/1ps
module test_pfce_guard;
    localparam int GRACE = 3;
    localparam int RECOV = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_ce_n = 1'b1;
    logic pwr_fail = 1'b0;
    logic us_tick = 1'b0;
    logic mem_ce_n;
    logic protect_on;

    int total = 0;
    int bad = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pfce_guard #(.GRACE_TICKS(GRACE), .RECOV_TICKS(RECOV)) i_pfce_guard (
        .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .pwr_fail(pwr_fail),
        .us_tick(us_tick), .mem_ce_n(mem_ce_n), .protect_on(protect_on)
    );

    // tick: one cycle in three
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            us_tick = (div == 0);
            div = (div + 1) % 3;
        end
    end

    // behavioural reference: phase 0 open, 1 grace, 2 locked, 3 settling
    int ph = 3;
    int gticks = 0;
    int rticks = 0;
    bit sa = 0, sb = 0;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            ph = 3; rticks = 0; gticks = 0; sa = 0; sb = 0;
        end else begin
            if (ph == 0) begin
                gticks = 0;
                if (sb) ph = host_ce_n ? 2 : 1;
            end else if (ph == 1) begin
                if (!sb) begin ph = 3; rticks = 0; end
                else if (host_ce_n) ph = 2;
                else if (us_tick) begin
                    gticks++;
                    if (gticks >= GRACE) ph = 2;
                end
            end else if (ph == 2) begin
                if (!sb) begin ph = 3; rticks = 0; end
            end else begin
                if (sb) ph = 2;
                else if (us_tick) begin
                    rticks++;
                    if (rticks >= RECOV) ph = 0;
                end
            end
            sb = sa;
            sa = pwr_fail;
        end
    end

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // cycle compare against the reference
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (started && !rst) begin
                logic em;
                em = (ph <= 1) ? host_ce_n : 1'b1;
                case (ph)
                    0: check("R2 mem_ce_n", mem_ce_n, em);
                    1: check("R5 mem_ce_n", mem_ce_n, em);
                    2: check("R4 mem_ce_n", mem_ce_n, em);
                    default: check("R7 mem_ce_n", mem_ce_n, em);
                endcase
                check("R10 protect_on", protect_on, ph >= 2);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam int SETTLE = RECOV * 3 + 12;

    initial begin
        logic [7:0] lf = 8'h5a;
        step(3);
        rst = 1'b0;
        host_ce_n = 1'b0;
        step(2);
        check("R1 protect after reset", protect_on, 1'b1);
        check("R1 mem blocked after reset", mem_ce_n, 1'b1);
        step(SETTLE);
        check("R1 released after interval", protect_on, 1'b0);
        check("R2 follows low", mem_ce_n, 1'b0);
        host_ce_n = 1'b1; #0.5;
        check("R2 follows high same cycle", mem_ce_n, 1'b1);

        // R3 latency and R4 idle entry
        pwr_fail = 1'b1;
        step(2);
        check("R3 no reaction after two edges", protect_on, 1'b0);
        step(1);
        check("R3 reacts on third edge", protect_on, 1'b1);
        host_ce_n = 1'b0; #0.5;
        check("R4 host low ignored while locked", mem_ce_n, 1'b1);
        step(4);
        check("R4 stays locked", mem_ce_n, 1'b1);
        pwr_fail = 1'b0;
        step(RECOV * 3 - 6);
        check("R7 still held during interval", protect_on, 1'b1);
        step(20);
        check("R7 released after interval", protect_on, 1'b0);

        // R5 access in progress
        host_ce_n = 1'b0;
        pwr_fail = 1'b1;
        step(4);
        check("R5 access continues", mem_ce_n, 1'b0);
        check("R10 no protect under grace", protect_on, 1'b0);
        host_ce_n = 1'b1;
        step(1);
        host_ce_n = 1'b0;
        step(2);
        check("R5 blocked after release", mem_ce_n, 1'b1);
        pwr_fail = 1'b0;
        step(SETTLE);

        // R6 grace expiry
        host_ce_n = 1'b0;
        pwr_fail = 1'b1;
        step(3 + GRACE * 3 + 4);
        check("R6 forced high after grace", mem_ce_n, 1'b1);
        check("R6 protect after grace", protect_on, 1'b1);

        // R8 fault during recovery
        pwr_fail = 1'b0;
        step(20);
        pwr_fail = 1'b1;
        step(5);
        check("R8 relocked", protect_on, 1'b1);
        pwr_fail = 1'b0;
        step(RECOV * 3 - 10);
        check("R8 count restarted", protect_on, 1'b1);
        step(30);
        check("R8 released after full interval", protect_on, 1'b0);

        // R9 fault clears under grace
        host_ce_n = 1'b0;
        pwr_fail = 1'b1;
        step(4);
        pwr_fail = 1'b0;
        step(3);
        check("R9 blocked on clear", mem_ce_n, 1'b1);
        check("R9 recovering", protect_on, 1'b1);
        step(SETTLE);

        // mixed traffic, reference compare each cycle
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            host_ce_n = lf[0];
            if (lf[7:3] == 5'h0b) pwr_fail = ~pwr_fail;
            step(1);
        end
        pwr_fail = 1'b0;
        step(SETTLE);
        check("R2 open at end", protect_on, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule